// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block drives four independent pulse-width modulated outputs from one clock. The same clock runs a small 32-bit register port and the modulation logic. A shared control word holds a run bit and a two-bit step-clock ratio for every channel. A per-channel setup word holds the period length (the timebase) and the high time (the duty). Both are counted in steps of the selected ratio.

Each channel has its own step generator. The generator is built from two cascaded sub-dividers: the first divides by 8 and the second by 64. Used alone or chained, they give step lengths of 1, 8, 64 or 512 clock cycles. The channel counter runs through the timebase and then wraps. The output is high while the counter is below the duty value. New setup values are copied into a working copy only when a period ends, so a running waveform never produces a truncated or stretched pulse. Software writes the setup words and then sets the run bits.

Top module: `qpwm_top`

## Requirements
- R1: The control word is at byte offset 0x0. Bit n is the run bit of channel n. Bits [5+2n:4+2n] hold the ratio code of channel n. The setup word of channel n is at offset 0x4+4n, with the timebase in bits [7:0] and the duty in bits [23:16]. A read returns the stored fields with all other bits zero. The read data appears on `bus_rdata` after the clock edge that takes the read request.
- R2: Ratio code 0 gives a step of 1 clock cycle. Code 1 uses the first sub-divider only (8 cycles). Code 2 uses the second sub-divider only (64 cycles). Code 3 chains both (512 cycles).
- R3: A running channel with timebase T > 0 and duty D repeats a period of T steps and is high for the first D steps of each period. The first period begins from count 0 one clock after the edge that makes the channel run.
- R4: A duty of 0 gives a constant low output. A duty equal to or above the timebase gives a constant high output.
- R5: From one clock after its run bit is cleared, a channel's output is low. Its counter and step generator are cleared. Setting the run bit again restarts the waveform from count 0.
- R6: A new timebase or duty written while a channel runs has no effect until the current period ends. The new values take effect from the next period.
- R7: A channel whose timebase is 0 holds its output low from one clock after that value is stored.
- R8: The four channels run independently, each with its own ratio, timebase and duty.
- R9: After reset, all stored fields are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register port and the modulators |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | Modulated outputs, bit n = channel n, high-active |

## Verification
A write is stored at the edge that takes it. A change to a run bit or a timebase reaches `pwm_out` one clock later, because the running state is held in a register. A setup change on a running channel becomes visible only at the period boundary that follows the write. The bench records the edge index of every write. From that index it computes, for every following clock, the expected level of each output, starting one clock after the write and shifting any change to the next period boundary. The monitor compares those items at the falling edge of the matching cycle. Read data is sampled at the falling edge after the edge that takes the read request.

// File: rtl/qpwm_pkg.sv
`timescale 1ns/1ps
package qpwm_pkg;

  // Step-clock ratio codes; bit 0 engages the first sub-divider, bit 1 the second
  typedef enum logic [1:0] {
    PSC_DIV1   = 2'd0,
    PSC_SUB_A  = 2'd1,
    PSC_SUB_B  = 2'd2,
    PSC_SUB_AB = 2'd3
  } psc_sel_e;

  localparam int PSC_W      = 2;
  localparam int CTRL_OFS   = 0;
  localparam int CFG_BASE   = 4;
  localparam int CFG_STRIDE = 4;
  localparam int PSC_LSB    = 4;
  localparam int DUTY_LSB   = 16;

endpackage

// File: rtl/qpwm_regfile.sv
`timescale 1ns/1ps
module qpwm_regfile
  import qpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_valid,
  input  logic                               bus_write,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [DATA_W-1:0]                  bus_wdata,
  output logic [DATA_W-1:0]                  bus_rdata,
  output logic [NUM_CH-1:0]                  run_o,
  output logic [NUM_CH-1:0][PSC_W-1:0]       psc_o,
  output logic [NUM_CH-1:0][TB_W-1:0]        tb_o,
  output logic [NUM_CH-1:0][TB_W-1:0]        duty_o
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

  logic [NUM_CH-1:0]            run_q, run_d;
  logic [NUM_CH-1:0][PSC_W-1:0] psc_q, psc_d;
  logic [NUM_CH-1:0][TB_W-1:0]  tb_q, tb_d;
  logic [NUM_CH-1:0][TB_W-1:0]  du_q, du_d;
  logic [DATA_W-1:0]            rd_q, rd_d;
  logic                         wr_req, rd_req, ctrl_hit;
  logic                         cfg_en;
  logic [NUM_CH-1:0]            cfg_hit;

  always_comb begin
    wr_req   = bus_valid & bus_write;
    rd_req   = bus_valid & ~bus_write;
    ctrl_hit = (bus_addr == CTRL_ADDR);
    for (int c = 0; c < NUM_CH; c++) begin
      cfg_hit[c] = (bus_addr == ADDR_W'(CFG_BASE + CFG_STRIDE * c));
    end
    cfg_en = wr_req & (|cfg_hit);
  end

  // Next-state for the control word
  always_comb begin
    run_d = run_q;
    psc_d = psc_q;
    if (wr_req && ctrl_hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        run_d[c] = bus_wdata[c];
        psc_d[c] = bus_wdata[PSC_LSB + PSC_W * c +: PSC_W];
      end
    end
  end

  // Next-state for the channel setup words
  always_comb begin
    tb_d = tb_q;
    du_d = du_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (wr_req && cfg_hit[c]) begin
        tb_d[c] = bus_wdata[TB_W-1:0];
        du_d[c] = bus_wdata[DUTY_LSB +: TB_W];
      end
    end
  end

  // Read mux; unmapped offsets read as zero
  always_comb begin
    rd_d = '0;
    if (ctrl_hit) begin
      for (int c = 0; c < NUM_CH; c++) begin
        rd_d[c]                              = run_q[c];
        rd_d[PSC_LSB + PSC_W * c +: PSC_W]   = psc_q[c];
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (cfg_hit[c]) begin
        rd_d[TB_W-1:0]         = tb_q[c];
        rd_d[DUTY_LSB +: TB_W] = du_q[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      psc_q <= '0;
    end else if (wr_req && ctrl_hit) begin
      run_q <= run_d;
      psc_q <= psc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0;
      du_q <= '0;
    end else if (cfg_en) begin
      tb_q <= tb_d;
      du_q <= du_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_req) begin
      rd_q <= rd_d;
    end
  end

  assign bus_rdata = rd_q;
  assign run_o     = run_q;
  assign psc_o     = psc_q;
  assign tb_o      = tb_q;
  assign duty_o    = du_q;

endmodule

// File: rtl/qpwm_prescaler.sv
`timescale 1ns/1ps
module qpwm_prescaler
  import qpwm_pkg::*;
#(
  parameter int A_W = 3,
  parameter int B_W = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  psc_sel_e sel_i,
  output logic     tick_o
);

  logic [A_W-1:0] a_q, a_d;
  logic [B_W-1:0] b_q, b_d;
  logic           use_a, use_b, a_in, b_in, a_wrap, b_wrap;

  always_comb begin
    use_a  = sel_i[0];
    use_b  = sel_i[1];
    a_in   = use_a & ~clr_i;
    a_wrap = a_in & (a_q == '1);
    b_in   = use_b & ~clr_i & (use_a ? a_wrap : 1'b1);
    b_wrap = b_in & (b_q == '1);
  end

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (clr_i) begin
      a_d = '0;
      b_d = '0;
    end else begin
      if (a_in) a_d = a_q + A_W'(1);
      if (b_in) b_d = b_q + B_W'(1);
    end
  end

  always_comb begin
    case (sel_i)
      PSC_DIV1:  tick_o = ~clr_i;
      PSC_SUB_A: tick_o = a_wrap;
      default:   tick_o = b_wrap;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  AST_FIRST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && $past(clr_i) && sel_i != PSC_DIV1) |-> !tick_o)
    else $error("divided step fired right after clear"); // R2

endmodule

// File: rtl/qpwm_channel.sv
`timescale 1ns/1ps
module qpwm_channel #(
  parameter int TB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [TB_W-1:0] tb_i,
  input  logic [TB_W-1:0] duty_i,
  input  logic            tick_i,
  output logic            act_o,
  output logic            pwm_o
);

  logic            act_q, act_d;
  logic [TB_W-1:0] cnt_q, cnt_d;
  logic [TB_W-1:0] sh_tb_q, sh_tb_d;
  logic [TB_W-1:0] sh_du_q, sh_du_d;
  logic            last_step, wrap, load, cnt_en;

  always_comb begin
    act_d     = run_i & (tb_i != '0);
    last_step = (cnt_q == sh_tb_q - TB_W'(1));
    wrap      = act_q & tick_i & last_step;
    load      = ~act_q | wrap;
    cnt_en    = ~act_q | tick_i;
  end

  always_comb begin
    cnt_d   = cnt_q;
    sh_tb_d = sh_tb_q;
    sh_du_d = sh_du_q;
    if (!act_q || last_step) cnt_d = '0;
    else                     cnt_d = cnt_q + TB_W'(1);
    if (load) begin
      sh_tb_d = tb_i;
      sh_du_d = duty_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_tb_q <= '0;
      sh_du_q <= '0;
    end else if (load) begin
      sh_tb_q <= sh_tb_d;
      sh_du_q <= sh_du_d;
    end
  end

  assign act_o = act_q;
  assign pwm_o = act_q & (cnt_q < sh_du_q);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < sh_tb_q))
    else $error("step counter beyond working timebase"); // R3

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && !$past(wrap)) |-> ($stable(sh_tb_q) && $stable(sh_du_q)))
    else $error("working copy changed inside a period"); // R6

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && $past(!act_q)) |-> (cnt_q == '0))
    else $error("idle channel counter not cleared"); // R5

endmodule

// File: rtl/qpwm_top.sv
`timescale 1ns/1ps
module qpwm_top
  import qpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SUBA_W = 3,
  parameter int SUBB_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [NUM_CH-1:0]            run;
  logic [NUM_CH-1:0][PSC_W-1:0] psc;
  logic [NUM_CH-1:0][TB_W-1:0]  tb;
  logic [NUM_CH-1:0][TB_W-1:0]  duty;
  logic [NUM_CH-1:0]            act;
  logic [NUM_CH-1:0]            tick;

  qpwm_regfile #(
    .NUM_CH (NUM_CH),
    .TB_W   (TB_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .run_o     (run),
    .psc_o     (psc),
    .tb_o      (tb),
    .duty_o    (duty)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qpwm_prescaler #(
      .A_W (SUBA_W),
      .B_W (SUBB_W)
    ) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (~act[c]),
      .sel_i  (psc_sel_e'(psc[c])),
      .tick_o (tick[c])
    );

    qpwm_channel #(
      .TB_W (TB_W)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run[c]),
      .tb_i   (tb[c]),
      .duty_i (duty[c]),
      .tick_i (tick[c]),
      .act_o  (act[c]),
      .pwm_o  (pwm_out[c])
    );

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] |=> !pwm_out[c])
      else $error("stopped channel output not low"); // R5

    AST_TB_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tb[c] == '0) |=> !pwm_out[c])
      else $error("zero timebase channel output not low"); // R7
  end

endmodule

// File: tb/qpwm_top_tb.sv
`timescale 1ns/1ps
module qpwm_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int NEVER      = 32'h7fff_ffff;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  int         q_cyc[$];
  logic [3:0] q_val[$];
  string      q_tag[$];

  bit m_on [NCH];
  int m_t0 [NCH];
  int m_tb [NCH];
  int m_du [NCH];
  int m_div[NCH];
  int m_sw [NCH];
  int m_tb2[NCH];
  int m_du2[NCH];

  qpwm_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Monitor: pops the item due this cycle and compares it
  always @(negedge clk) begin
    logic [3:0] e;
    string      tg;
    while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
      void'(q_cyc.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
    if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
      void'(q_cyc.pop_front());
      e  = q_val.pop_front();
      tg = q_tag.pop_front();
      chk(pwm_out === e, tg, "pwm_out", {28'd0, pwm_out}, {28'd0, e});
    end
  end

  function automatic bit exp_bit(int c, int t);
    int rel, tb, du;
    if (!m_on[c]) return 1'b0;
    if (t >= m_sw[c]) begin
      rel = t - m_sw[c]; tb = m_tb2[c]; du = m_du2[c];
    end else begin
      rel = t - m_t0[c]; tb = m_tb[c]; du = m_du[c];
    end
    if (rel < 0 || tb == 0) return 1'b0;
    return ((rel / m_div[c]) % tb) < du;
  endfunction

  task automatic push_window(input int from, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [3:0] v;
      for (int c = 0; c < NCH; c++) v[c] = exp_bit(c, from + k);
      q_cyc.push_back(from + k);
      q_val.push_back(v);
      q_tag.push_back(tag);
    end
    while (cyc < from + n) @(negedge clk);
  endtask

  task automatic set_ch(input int c, input int t0, input int tb, input int du, input int dv);
    m_on[c] = (tb != 0); m_t0[c] = t0; m_tb[c] = tb; m_du[c] = du;
    m_div[c] = dv; m_sw[c] = NEVER;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, output int tw);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    tw = cyc;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk);
    #1;
    bus_valid = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int          tw, m;
    logic [31:0] rd;
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 0, 0, 1);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk(pwm_out == 4'b0, "R9", "outputs after reset", {28'd0, pwm_out}, 32'd0);
    bus_rd(8'h00, rd); chk(rd == 32'd0, "R9", "control after reset", rd, 32'd0);
    bus_rd(8'h08, rd); chk(rd == 32'd0, "R9", "setup1 after reset", rd, 32'd0);

    // R1: field layout and read-back
    bus_wr(8'h04, 32'h0003_000A, tw);
    bus_wr(8'h08, 32'h0001_0004, tw);
    bus_wr(8'h0C, 32'hFF02_AB03, tw);
    bus_wr(8'h10, 32'h0001_0002, tw);
    bus_rd(8'h0C, rd); chk(rd == 32'h0002_0003, "R1", "setup2 readback", rd, 32'h0002_0003);
    bus_rd(8'h10, rd); chk(rd == 32'h0001_0002, "R1", "setup3 readback", rd, 32'h0001_0002);

    // R2 R3 R8: all four ratios at once, codes 0,1,2,3 on channels 0..3
    bus_wr(8'h00, 32'h0000_0E4F, tw);
    set_ch(0, tw + 1, 10, 3, 1);
    set_ch(1, tw + 1, 4, 1, 8);
    set_ch(2, tw + 1, 3, 2, 64);
    set_ch(3, tw + 1, 2, 1, 512);
    push_window(tw + 1, 2200, "R2 R3 R8");
    bus_rd(8'h00, rd); chk(rd == 32'h0000_0E4F, "R1", "control readback", rd, 32'h0000_0E4F);

    // R6: new setup mid-period waits for the boundary
    bus_wr(8'h04, 32'h0005_0006, tw);
    m = (tw - m_t0[0]) / 10 + 1;
    m_sw[0] = m_t0[0] + m * 10; m_tb2[0] = 6; m_du2[0] = 5;
    push_window(tw + 1, 80, "R6");

    // R7: timebase 0 forces low
    bus_wr(8'h0C, 32'h0002_0000, tw);
    m_on[2] = 1'b0;
    push_window(tw + 1, 300, "R7");

    // R5: all stopped
    bus_wr(8'h00, 32'h0000_0000, tw);
    for (int c = 0; c < NCH; c++) m_on[c] = 1'b0;
    push_window(tw + 1, 100, "R5");

    // R4: duty 0, duty = timebase, duty above timebase
    bus_wr(8'h04, 32'h0000_0005, tw);
    bus_wr(8'h08, 32'h0005_0005, tw);
    bus_wr(8'h0C, 32'h0003_0008, tw);
    bus_wr(8'h10, 32'h0009_0004, tw);
    bus_wr(8'h00, 32'h0000_000F, tw);
    set_ch(0, tw + 1, 5, 0, 1);
    set_ch(1, tw + 1, 5, 5, 1);
    set_ch(2, tw + 1, 8, 3, 1);
    set_ch(3, tw + 1, 4, 9, 1);
    push_window(tw + 1, 100, "R4 R5");

    // R5: one channel stopped then restarted from count 0 (code 1)
    bus_wr(8'h00, 32'h0000_000B, tw);
    m_on[2] = 1'b0;
    push_window(tw + 1, 20, "R5");
    bus_wr(8'h00, 32'h0000_010F, tw);
    set_ch(2, tw + 1, 8, 3, 8);
    push_window(tw + 1, 200, "R5 R2");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule